// File: doc/BRIEF.md
# Hardware Mutex Register Bank

This block holds an array of one-bit hardware mutex flags that several processors reach over a shared register bus to guard common resources. Each flag has its own word-aligned register. A read of that register is an atomic test-and-set: it returns whether the flag was already held, and the flag is held once the read completes. A processor that reads back zero owns the lock. It gives the lock up by writing zero to the same register.

The bus is a simple single-cycle port with one address, a read strobe, a write strobe and 32-bit data in each direction. Read data is registered and appears the cycle after the read strobe. A read-only status word at offset zero reports the number of locks as a small power-of-two code, so software can size its lock table. The lock count is a build-time parameter: 32, 64, 128 or 256.

Top module: `hw_mutex_bank`

## Requirements
- R1: After synchronous reset every lock is free and `bus_rdata` is 0.
- R2: A read of offset 0x000 returns the status word. Bits 30:28 hold the code log2(NUM_LOCKS)-4 (1, 2, 3 or 4 for 32, 64, 128 or 256 locks) and all other bits are 0, so the 32-lock build reads 0x10000000.
- R3: Lock n is at offset 0x100 + 4*n. A read of a free lock returns 0 and leaves the lock held.
- R4: A read of a held lock returns 1 and leaves every lock unchanged.
- R5: A write of the value 0 to a lock register frees that lock.
- R6: A write of any nonzero value to a lock register changes no lock.
- R7: An access to a lock index at or beyond NUM_LOCKS, to an unmapped offset, or to an address whose two low bits are not zero reads 0 and changes no lock.
- R8: A write to the status offset has no effect. The status word reads the same afterwards.
- R9: If the read and write strobes are both asserted on a lock in the same cycle with write data 0, the release is applied first. The read returns 0 and the lock ends held.
- R10: Read data is valid in the cycle after the read strobe. In any cycle after a clock edge without a read strobe, `bus_rdata` is 0.
- R11: Each lock's state is independent. Acquiring or releasing one lock never changes another.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |

## Verification
Every result is due exactly one clock edge after its strobe. The read value and the lock update are both taken at the edge where the strobe is sampled, so the lock's new state shows on the next read.

The bench drives the strobes at the falling edge. For each read it queues the expected word, and its monitor samples `bus_rdata` shortly after the rising edge that took the strobe. Checks of effects that must be absent, such as ignored writes and stray addresses, are made with a later read of the affected lock. The idle-cycle check samples `bus_rdata` one edge after a cycle with no read strobe.

// File: rtl/mtx_pkg.sv
package mtx_pkg;

    localparam int unsigned LOCK_BASE   = 32'h100;
    localparam int unsigned MAX_IDX_W   = 8;
    localparam int unsigned CODE_LSB    = 28;

    typedef enum logic [1:0] {
        ACC_NONE   = 2'd0,
        ACC_STATUS = 2'd1,
        ACC_LOCK   = 2'd2
    } acc_kind_e;

    typedef struct packed {
        acc_kind_e              kind;
        logic [MAX_IDX_W-1:0]   idx;
    } acc_t;

    function automatic logic [2:0] count_code(input int unsigned n);
        return 3'($clog2(n) - 4);
    endfunction

    function automatic logic [31:0] status_word(input int unsigned n);
        logic [31:0] w;
        w = '0;
        w[CODE_LSB +: 3] = count_code(n);
        return w;
    endfunction

endpackage

// File: rtl/mtx_decode.sv
module mtx_decode
    import mtx_pkg::*;
#(
    parameter int unsigned NUM_LOCKS = 32,
    parameter int unsigned ADDR_W    = 12
) (
    input  logic [ADDR_W-1:0] addr,
    output acc_t              acc
);
    logic [ADDR_W-1:0] word;
    logic              aligned;
    logic              in_lock;

    always_comb begin
        word    = (addr - ADDR_W'(LOCK_BASE)) >> 2;
        aligned = (addr[1:0] == 2'b00);
        in_lock = aligned && (addr >= ADDR_W'(LOCK_BASE))
                  && (word < ADDR_W'(NUM_LOCKS));
        acc.idx = word[MAX_IDX_W-1:0];
        if (addr == '0)
            acc.kind = ACC_STATUS;
        else if (in_lock)
            acc.kind = ACC_LOCK;
        else
            acc.kind = ACC_NONE;
    end
endmodule

// File: rtl/mtx_lock_array.sv
module mtx_lock_array
    import mtx_pkg::*;
#(
    parameter int unsigned NUM_LOCKS = 32
) (
    input  logic                 clk,
    input  logic                 rst,
    input  acc_t                 acc,
    input  logic                 rd,
    input  logic                 wr,
    input  logic                 wr_zero,
    output logic [NUM_LOCKS-1:0] lock_q,
    output logic                 held_view
);
    logic [NUM_LOCKS-1:0] sel_v;
    logic [NUM_LOCKS-1:0] rel_v;
    logic [NUM_LOCKS-1:0] acq_v;

    for (genvar i = 0; i < NUM_LOCKS; i++) begin : g_lock
        assign sel_v[i] = (acc.kind == ACC_LOCK) && (acc.idx == MAX_IDX_W'(i));
        assign rel_v[i] = sel_v[i] && wr && wr_zero;
        assign acq_v[i] = sel_v[i] && rd;

        always_ff @(posedge clk) begin
            if (rst)
                lock_q[i] <= 1'b0;
            else
                lock_q[i] <= (lock_q[i] & ~rel_v[i]) | acq_v[i];
        end
    end

    // a same-cycle release is visible to the read (release first)
    assign held_view = |(lock_q & ~rel_v & sel_v);
endmodule

// File: rtl/hw_mutex_bank.sv
module hw_mutex_bank
    import mtx_pkg::*;
#(
    parameter int unsigned NUM_LOCKS = 32,
    parameter int unsigned ADDR_W    = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata
);
    localparam logic [31:0] STATUS_VAL = status_word(NUM_LOCKS);

    acc_t                 acc;
    logic [NUM_LOCKS-1:0] lock_q;
    logic                 held_view;
    logic [31:0]          rd_val;

    mtx_decode #(.NUM_LOCKS(NUM_LOCKS), .ADDR_W(ADDR_W)) u_dec (
        .addr (bus_addr),
        .acc  (acc)
    );

    mtx_lock_array #(.NUM_LOCKS(NUM_LOCKS)) u_arr (
        .clk       (clk),
        .rst       (rst),
        .acc       (acc),
        .rd        (bus_rd),
        .wr        (bus_wr),
        .wr_zero   (bus_wdata == 32'd0),
        .lock_q    (lock_q),
        .held_view (held_view)
    );

    always_comb begin
        unique case (acc.kind)
            ACC_STATUS: rd_val = STATUS_VAL;
            ACC_LOCK:   rd_val = {31'd0, held_view};
            default:    rd_val = 32'd0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            bus_rdata <= 32'd0;
        else if (bus_rd)
            bus_rdata <= rd_val;
        else
            bus_rdata <= 32'd0;
    end
endmodule

// File: rtl/hw_mutex_bank_checker.sv
module hw_mutex_bank_checker #(
    parameter int unsigned NUM_LOCKS = 32,
    parameter int unsigned ADDR_W    = 12
) (
    input logic                 clk,
    input logic                 rst,
    input logic [ADDR_W-1:0]    bus_addr,
    input logic                 bus_rd,
    input logic                 bus_wr,
    input logic [31:0]          bus_wdata,
    input logic [31:0]          bus_rdata,
    input logic [NUM_LOCKS-1:0] lock_q
);
    localparam int unsigned STAT_CODE = $clog2(NUM_LOCKS) - 4;

    int unsigned cidx;
    logic        hit;
    logic        rel0;

    always_comb begin
        cidx = (int'(bus_addr) - 256) / 4;
        hit  = (bus_addr[1:0] == 2'b00) && (int'(bus_addr) >= 256)
               && (cidx < NUM_LOCKS);
        rel0 = bus_wr && (bus_wdata == 32'd0);
    end

    a_r2_status_value: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr == '0) |=> (bus_rdata[30:28] == STAT_CODE[2:0]
                                        && bus_rdata[27:0] == 28'd0
                                        && bus_rdata[31] == 1'b0));

    a_r3_free_read_acquires: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && hit && !rel0 && !lock_q[cidx])
        |=> (bus_rdata == 32'd0 && lock_q[$past(cidx)]));

    a_r4_held_read_stable: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && hit && !rel0 && lock_q[cidx])
        |=> (bus_rdata == 32'd1 && $stable(lock_q)));

    a_r5_zero_write_frees: assert property (@(posedge clk) disable iff (rst)
        (rel0 && !bus_rd && hit) |=> !lock_q[$past(cidx)]);

    a_r6_nonzero_write_ignored: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && !bus_rd && bus_wdata != 32'd0) |=> $stable(lock_q));

    a_r7_stray_access: assert property (@(posedge clk) disable iff (rst)
        ((bus_rd || bus_wr) && !hit && bus_addr != '0)
        |=> (bus_rdata == 32'd0 && $stable(lock_q)));

    a_r9_reader_wins: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && rel0 && hit) |=> (bus_rdata == 32'd0 && lock_q[$past(cidx)]));

    a_r10_idle_zero: assert property (@(posedge clk) disable iff (rst)
        !bus_rd |=> bus_rdata == 32'd0);

    a_r11_single_change: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> $countones(lock_q ^ $past(lock_q)) <= 1);
endmodule

bind hw_mutex_bank hw_mutex_bank_checker #(
    .NUM_LOCKS (NUM_LOCKS),
    .ADDR_W    (ADDR_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_rd    (bus_rd),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .lock_q    (lock_q)
);

// File: tb/hw_mutex_bank_tb.sv
module hw_mutex_bank_tb;
    localparam int unsigned NUM_LOCKS = 32;
    localparam int unsigned ADDR_W    = 12;
    localparam logic [31:0] EXP_STAT  = 32'h1000_0000;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic              bus_rd = 1'b0;
    logic              bus_wr = 1'b0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;

    int checks = 0;
    int fails  = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #5 clk = ~clk;

    hw_mutex_bank #(.NUM_LOCKS(NUM_LOCKS), .ADDR_W(ADDR_W)) u_dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    function automatic logic [ADDR_W-1:0] lk(input int n);
        return ADDR_W'(256 + 4 * n);
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic access(input logic [ADDR_W-1:0] a, input logic rd, input logic wr,
                          input logic [31:0] d, input logic [31:0] exp, input string tag);
        @(negedge clk);
        bus_addr = a; bus_rd = rd; bus_wr = wr; bus_wdata = d;
        if (rd) begin
            exp_q.push_back(exp);
            tag_q.push_back(tag);
        end
        @(negedge clk);
        bus_rd = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd_chk(input logic [ADDR_W-1:0] a, input logic [31:0] exp, input string tag);
        access(a, 1'b1, 1'b0, 32'd0, exp, tag);
    endtask

    task automatic wr_do(input logic [ADDR_W-1:0] a, input logic [31:0] d);
        access(a, 1'b0, 1'b1, d, 32'd0, "");
    endtask

    // monitor: result is due one edge after the strobe
    always @(posedge clk) begin
        if (bus_rd && !rst) begin
            #2;
            if (exp_q.size() == 0) begin
                checks++; fails++;
                $display("FAIL monitor: unexpected read result 0x%08h expected none", bus_rdata);
            end else begin
                check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        check("R1 reset rdata", bus_rdata, 32'd0);

        rd_chk('0, EXP_STAT, "R2 status word");
        rd_chk(lk(0), 32'd0, "R1 R3 lock0 free after reset");
        rd_chk(lk(0), 32'd1, "R4 lock0 held");
        rd_chk(lk(31), 32'd0, "R3 last lock free");
        rd_chk(lk(31), 32'd1, "R4 last lock held");
        rd_chk(lk(1), 32'd0, "R11 lock1 untouched by lock0");

        wr_do(lk(0), 32'h5);
        rd_chk(lk(0), 32'd1, "R6 nonzero write ignored");
        wr_do(lk(0), 32'd0);
        rd_chk(lk(0), 32'd0, "R5 zero write frees lock0");
        rd_chk(lk(1), 32'd1, "R11 lock1 still held");

        rd_chk(lk(32), 32'd0, "R7 index beyond count");
        rd_chk(lk(32), 32'd0, "R7 index beyond count no acquire");
        rd_chk(12'h004, 32'd0, "R7 unmapped offset");
        rd_chk(lk(2) + 12'd1, 32'd0, "R7 misaligned read");
        rd_chk(lk(2), 32'd0, "R7 misaligned read did not acquire lock2");
        wr_do(lk(32), 32'd0);
        rd_chk(lk(31), 32'd1, "R7 stray write left lock31 held");

        wr_do('0, 32'hFFFF_FFFF);
        rd_chk('0, EXP_STAT, "R8 status write ignored");

        rd_chk(lk(5), 32'd0, "R3 lock5 acquire");
        access(lk(5), 1'b1, 1'b1, 32'd0, 32'd0, "R9 same-cycle release and read");
        rd_chk(lk(5), 32'd1, "R9 reader holds lock5");

        @(negedge clk);
        @(negedge clk);
        check("R10 idle rdata", bus_rdata, 32'd0);

        repeat (3) @(negedge clk);
        if (exp_q.size() != 0) begin
            checks++; fails++;
            $display("FAIL R10: got %0d pending results expected 0", exp_q.size());
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule